// File: doc/BRIEF.md
# Permission-Gated Set-Associative Tag Directory

This block keeps the tag and state side of a set-associative cache and stores no data. Every way of every set records whether it is occupied, the full line address it holds, a two-bit access permission and a lock reservation, which is an owner context plus an "engaged" flag. A controller sends one command at a time: check an access against the stored permission, test presence or set availability, allocate, deallocate, update a permission, probe for the replacement victim, promote a way to most recently used, or set, clear and test the lock. The directory answers each one with a registered response.

A line is only found when its tag matches and its permission is not "absent". An access is granted only when the permission suits the request kind. Replacement uses a binary-tree pseudo-LRU per set. Allocation always fills the lowest free way, so the tree is consulted only when a set is full and the controller asks for a victim.

Top module: `tag_dir`

## Requirements
- R1: After reset no response is pending, `req_ready` is 1, every way of every set is empty and all replacement bits are cleared.
- R2: Permission codes are 0 absent, 1 invalid, 2 read-only and 3 read-write. A way counts as found for a line address only when it is occupied, its stored address equals the line address and its permission is not 0. The presence command (op 1) returns `rsp_ok` = found and `rsp_way` = the found way.
- R3: The access command (op 0) grants (`rsp_ok`=1) when the found line holds permission 3 for any request kind, or permission 2 when the kind is load (0) or instruction fetch (1). Kinds store (2) and atomic (3) are denied on permission 2. Every other case, including a miss, is denied.
- R4: A found line is made most recently used by the access command, whether granted or denied, and by the touch command (op 6). A miss leaves the replacement state as it was.
- R5: The availability command (op 2) returns 1 when some way of the set is occupied with the same address (any permission), or is empty, or holds permission 0.
- R6: Allocate (op 3) writes the address into the lowest-numbered way that is empty or has permission 0. It sets the permission to 1 and releases the lock, makes that way most recently used, and returns it in `rsp_way`.
- R7: Probe (op 5) on a set with no free way returns the full stored line address of the pseudo-LRU victim in `rsp_victim` and its way in `rsp_way`. Heap node n (root 1) has children 2n and 2n+1. Touching a way sets every node on its path to point away from it, and the victim follows the node bits from the root.
- R8: Lock-set (op 7) records `req_ctx` as owner of the found line and lock-clear (op 8) releases it. Lock-test (op 9) returns 1 only while the lock is engaged with an owner equal to `req_ctx`.
- R9: Deallocate (op 4) empties the found way. Permission-write (op 10) stores `req_perm` into the found line, and writing 0 makes the line no longer found.
- R10: Allocate on a found line or a full set, probe on an available set, and deallocate, permission-write or any lock command on a line that is not found, all return `rsp_err`=1 with `rsp_ok`=0 and change no state.
- R11: A command is accepted when `req_valid` and `req_ready` are both 1. Its response appears on the next cycle and is held unchanged while `rsp_ready` is 0, and during that time `req_ready` is 0.
- R12: The set index is the SET_W bits of the line address that start at bit IDX_LO. Addresses that differ in any other bit are distinct lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Command can be taken this cycle |
| req_op | input | 4 | Command code |
| req_line | input | LINE_W | Line address |
| req_kind | input | 2 | Request kind for access checks |
| req_ctx | input | CTX_W | Requester context for lock commands |
| req_perm | input | 2 | New permission for permission-write |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_ok | output | 1 | Hit, grant, availability or lock-test result |
| rsp_err | output | 1 | Illegal command, state unchanged |
| rsp_way | output | WAY_W | Found, allocated or victim way |
| rsp_victim | output | LINE_W | Victim line address on probe |

## Verification
The bench builds the directory with eight sets of four ways and IDX_LO set to 2. With that offset, the low address bits sit below the index and are still part of the tag, so two lines that differ only there must stay distinct. Four ways give a two-level tree, which makes the victim depend on the order in which ways were touched, and one small set fills after four allocations, which brings the full-set errors and probes within a few commands. A behavioural model of every way predicts each response, and the bench compares all response fields on every command, including error commands whose later effect, if any, would show up in presence and probe results.

// File: rtl/tdir_pkg.sv
package tdir_pkg;
   typedef enum logic [3:0] {
      OP_ACCESS   = 4'd0,
      OP_PRESENT  = 4'd1,
      OP_AVAIL    = 4'd2,
      OP_ALLOC    = 4'd3,
      OP_DEALLOC  = 4'd4,
      OP_PROBE    = 4'd5,
      OP_TOUCH    = 4'd6,
      OP_LOCK_SET = 4'd7,
      OP_LOCK_CLR = 4'd8,
      OP_LOCK_TST = 4'd9,
      OP_PERM_WR  = 4'd10
   } op_e;

   typedef enum logic [1:0] {
      PM_ABSENT = 2'd0,
      PM_INVAL  = 2'd1,
      PM_RDONLY = 2'd2,
      PM_RDWR   = 2'd3
   } perm_e;

   typedef enum logic [1:0] {
      KD_LOAD  = 2'd0,
      KD_FETCH = 2'd1,
      KD_STORE = 2'd2,
      KD_ATOM  = 2'd3
   } kind_e;
endpackage

// File: rtl/tdir_match.sv
module tdir_match #(
   parameter int ASSOC  = 4,
   parameter int LINE_W = 12,
   localparam int WAY_W = $clog2(ASSOC)
) (
   input  logic [LINE_W-1:0]             line,
   input  logic [ASSOC-1:0][LINE_W-1:0]  row_tag,
   input  logic [ASSOC-1:0]              row_vld,
   input  logic [ASSOC-1:0][1:0]         row_perm,
   output logic                          hit_any,
   output logic [WAY_W-1:0]              hit_way,
   output logic                          free_any,
   output logic [WAY_W-1:0]              free_way,
   output logic                          tagm_any
);
   logic [ASSOC-1:0] tagm, hit, free;

   for (genvar w = 0; w < ASSOC; w++) begin : g_way
      assign tagm[w] = row_vld[w] && (row_tag[w] == line);
      assign hit[w]  = tagm[w] && (row_perm[w] != 2'd0);
      assign free[w] = !row_vld[w] || (row_perm[w] == 2'd0);
   end

   assign hit_any  = |hit;
   assign free_any = |free;
   assign tagm_any = |tagm;

   // descending scan: the lowest-numbered matching way wins
   always_comb begin
      hit_way  = '0;
      free_way = '0;
      for (int w = ASSOC - 1; w >= 0; w--) begin
         if (hit[w])  hit_way  = WAY_W'(w);
         if (free[w]) free_way = WAY_W'(w);
      end
   end
endmodule

// File: rtl/tdir_plru.sv
module tdir_plru #(
   parameter int ASSOC = 4,
   localparam int WAY_W = $clog2(ASSOC)
) (
   input  logic [ASSOC-1:1] bits,
   input  logic [WAY_W-1:0] touch_way,
   output logic [ASSOC-1:1] bits_nxt,
   output logic [WAY_W-1:0] victim
);
   // heap layout: root 1, children of n are 2n and 2n+1
   always_comb begin
      logic [WAY_W-1:0] node;
      logic             b;
      bits_nxt = bits;
      node     = WAY_W'(1);
      for (int l = 0; l < WAY_W; l++) begin
         b              = touch_way[WAY_W-1-l];
         bits_nxt[node] = ~b;
         node           = WAY_W'({node, b});
      end
   end

   always_comb begin
      logic [WAY_W-1:0] node;
      logic             b;
      victim = '0;
      node   = WAY_W'(1);
      for (int l = 0; l < WAY_W; l++) begin
         b                   = bits[node];
         victim[WAY_W-1-l]   = b;
         node                = WAY_W'({node, b});
      end
   end
endmodule

// File: rtl/tag_dir.sv
module tag_dir
   import tdir_pkg::*;
#(
   parameter int LINE_W      = 12,
   parameter int LINE_BYTES  = 16,
   parameter int TOTAL_BYTES = 512,
   parameter int ASSOC       = 4,
   parameter int IDX_LO      = 0,
   parameter int CTX_W       = 4,
   localparam int SETS  = TOTAL_BYTES / ASSOC / LINE_BYTES,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(ASSOC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [3:0]        req_op,
   input  logic [LINE_W-1:0] req_line,
   input  logic [1:0]        req_kind,
   input  logic [CTX_W-1:0]  req_ctx,
   input  logic [1:0]        req_perm,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic              rsp_ok,
   output logic              rsp_err,
   output logic [WAY_W-1:0]  rsp_way,
   output logic [LINE_W-1:0] rsp_victim
);
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("tag_dir: set count must be a power of two above 1");
   end
   if (ASSOC < 2 || (ASSOC & (ASSOC - 1)) != 0) begin : g_bad_assoc
      $error("tag_dir: associativity must be a power of two above 1");
   end
   if (IDX_LO + SET_W > LINE_W) begin : g_bad_idx
      $error("tag_dir: index field exceeds line address");
   end

   logic [LINE_W-1:0] tag_q  [SETS][ASSOC];
   logic              vld_q  [SETS][ASSOC];
   logic [1:0]        perm_q [SETS][ASSOC];
   logic              lk_q   [SETS][ASSOC];
   logic [CTX_W-1:0]  own_q  [SETS][ASSOC];
   logic [ASSOC-1:1]  plru_q [SETS];

   op_e               op;
   logic              accept;
   logic [SET_W-1:0]  set_idx;
   logic [ASSOC-1:0][LINE_W-1:0] row_tag;
   logic [ASSOC-1:0]             row_vld;
   logic [ASSOC-1:0][1:0]        row_perm;
   logic              hit_any, free_any, tagm_any, avail;
   logic [WAY_W-1:0]  hit_way, free_way, touch_way, victim_way;
   logic [1:0]        hit_perm;
   logic [ASSOC-1:1]  plru_nxt;

   assign op      = op_e'(req_op);
   assign req_ready = !rsp_valid || rsp_ready;
   assign accept  = req_valid && req_ready;
   assign set_idx = req_line[IDX_LO +: SET_W];

   for (genvar w = 0; w < ASSOC; w++) begin : g_row
      assign row_tag[w]  = tag_q[set_idx][w];
      assign row_vld[w]  = vld_q[set_idx][w];
      assign row_perm[w] = perm_q[set_idx][w];
   end

   tdir_match #(.ASSOC(ASSOC), .LINE_W(LINE_W)) u_match (
      .line(req_line), .row_tag(row_tag), .row_vld(row_vld), .row_perm(row_perm),
      .hit_any(hit_any), .hit_way(hit_way), .free_any(free_any),
      .free_way(free_way), .tagm_any(tagm_any)
   );

   assign avail     = tagm_any || free_any;
   assign hit_perm  = perm_q[set_idx][hit_way];
   assign touch_way = (op == OP_ALLOC) ? free_way : hit_way;

   tdir_plru #(.ASSOC(ASSOC)) u_plru (
      .bits(plru_q[set_idx]), .touch_way(touch_way),
      .bits_nxt(plru_nxt), .victim(victim_way)
   );

   logic ok_d, err_d, do_touch, do_alloc, do_dealloc, do_perm, do_lkset, do_lkclr;
   logic [WAY_W-1:0]  way_d;
   logic [LINE_W-1:0] vic_d;

   always_comb begin
      ok_d = 1'b0;  err_d = 1'b0;  way_d = '0;  vic_d = '0;
      do_touch = 1'b0;  do_alloc = 1'b0;  do_dealloc = 1'b0;
      do_perm = 1'b0;  do_lkset = 1'b0;  do_lkclr = 1'b0;
      unique case (op)
         OP_ACCESS: if (hit_any) begin
            way_d    = hit_way;
            do_touch = 1'b1;
            ok_d     = (hit_perm == PM_RDWR) ||
                       ((hit_perm == PM_RDONLY) &&
                        (req_kind == KD_LOAD || req_kind == KD_FETCH));
         end
         OP_PRESENT: begin
            ok_d  = hit_any;
            way_d = hit_any ? hit_way : '0;
         end
         OP_AVAIL: ok_d = avail;
         OP_ALLOC: if (hit_any || !free_any) err_d = 1'b1;
                   else begin
                      ok_d = 1'b1;  way_d = free_way;
                      do_alloc = 1'b1;  do_touch = 1'b1;
                   end
         OP_PROBE: if (avail) err_d = 1'b1;
                   else begin
                      ok_d  = 1'b1;
                      way_d = victim_way;
                      vic_d = tag_q[set_idx][victim_way];
                   end
         OP_TOUCH: if (hit_any) begin
            ok_d = 1'b1;  way_d = hit_way;  do_touch = 1'b1;
         end
         OP_DEALLOC, OP_LOCK_SET, OP_LOCK_CLR, OP_LOCK_TST, OP_PERM_WR:
            if (!hit_any) err_d = 1'b1;
            else begin
               way_d      = hit_way;
               ok_d       = (op == OP_LOCK_TST) ?
                            (lk_q[set_idx][hit_way] && own_q[set_idx][hit_way] == req_ctx) : 1'b1;
               do_dealloc = (op == OP_DEALLOC);
               do_perm    = (op == OP_PERM_WR);
               do_lkset   = (op == OP_LOCK_SET);
               do_lkclr   = (op == OP_LOCK_CLR);
            end
         default: err_d = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_ok <= 1'b0;  rsp_err <= 1'b0;
         rsp_way <= '0;   rsp_victim <= '0;
      end else if (accept) begin
         rsp_valid <= 1'b1;
         rsp_ok <= ok_d;  rsp_err <= err_d;
         rsp_way <= way_d;  rsp_victim <= vic_d;
      end else if (rsp_ready) begin
         rsp_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            plru_q[s] <= '0;
            for (int w = 0; w < ASSOC; w++) begin
               vld_q[s][w] <= 1'b0;  tag_q[s][w] <= '0;  perm_q[s][w] <= PM_ABSENT;
               lk_q[s][w]  <= 1'b0;  own_q[s][w] <= '0;
            end
         end
      end else if (accept) begin
         if (do_touch) plru_q[set_idx] <= plru_nxt;
         if (do_alloc) begin
            vld_q[set_idx][free_way]  <= 1'b1;
            tag_q[set_idx][free_way]  <= req_line;
            perm_q[set_idx][free_way] <= PM_INVAL;
            lk_q[set_idx][free_way]   <= 1'b0;
            own_q[set_idx][free_way]  <= '0;
         end
         if (do_dealloc) vld_q[set_idx][hit_way]  <= 1'b0;
         if (do_perm)    perm_q[set_idx][hit_way] <= req_perm;
         if (do_lkset) begin
            lk_q[set_idx][hit_way]  <= 1'b1;
            own_q[set_idx][hit_way] <= req_ctx;
         end
         if (do_lkclr)   lk_q[set_idx][hit_way] <= 1'b0;
      end
   end
endmodule

// File: rtl/tag_dir_chk.sv
module tag_dir_chk
   import tdir_pkg::*;
#(
   parameter int LINE_W = 12,
   parameter int WAY_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [3:0]        req_op,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic              rsp_ok,
   input logic              rsp_err,
   input logic [WAY_W-1:0]  rsp_way,
   input logic [LINE_W-1:0] rsp_victim,
   input logic              hit,
   input logic              avail,
   input logic [1:0]        hit_perm
);
   logic acc;
   assign acc = req_valid && req_ready;

   p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> rsp_valid);

   p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ok) && $stable(rsp_err)
                                 && $stable(rsp_way) && $stable(rsp_victim));

   p_err_not_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_err |-> !rsp_ok);

   p_rw_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_op == OP_ACCESS && hit && hit_perm == PM_RDWR |=> rsp_ok);

   p_miss_deny_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_op == OP_ACCESS && !hit |=> !rsp_ok && !rsp_err);

   p_alloc_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_op == OP_ALLOC && !hit && avail |=> !rsp_err && rsp_ok);

   p_probe_avail_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_op == OP_PROBE && avail |=> rsp_err);

   p_lock_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc && (req_op == OP_LOCK_SET || req_op == OP_LOCK_CLR || req_op == OP_LOCK_TST)
      && !hit |=> rsp_err);
endmodule

bind tag_dir tag_dir_chk #(.LINE_W(LINE_W), .WAY_W(WAY_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_op(req_op), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
   .rsp_ok(rsp_ok), .rsp_err(rsp_err), .rsp_way(rsp_way), .rsp_victim(rsp_victim),
   .hit(hit_any), .avail(avail), .hit_perm(hit_perm)
);

// File: tb/tag_dir_bench.sv
module tag_dir_bench;
   localparam int LINE_W = 12, LINE_BYTES = 16, TOTAL_BYTES = 512, ASSOC = 4;
   localparam int IDX_LO = 2, CTX_W = 4;
   localparam int SETS = TOTAL_BYTES / ASSOC / LINE_BYTES;
   localparam int SET_W = $clog2(SETS), WAY_W = $clog2(ASSOC);

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, rsp_ready = 1'b1;
   logic [3:0] req_op = '0;
   logic [LINE_W-1:0] req_line = '0;
   logic [1:0] req_kind = '0, req_perm = '0;
   logic [CTX_W-1:0] req_ctx = '0;
   logic req_ready, rsp_valid, rsp_ok, rsp_err;
   logic [WAY_W-1:0] rsp_way;
   logic [LINE_W-1:0] rsp_victim;

   always #10 clk = ~clk;

   tag_dir #(.LINE_W(LINE_W), .LINE_BYTES(LINE_BYTES), .TOTAL_BYTES(TOTAL_BYTES),
             .ASSOC(ASSOC), .IDX_LO(IDX_LO), .CTX_W(CTX_W)) u_tag_dir (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_line(req_line), .req_kind(req_kind), .req_ctx(req_ctx),
      .req_perm(req_perm), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_ok(rsp_ok), .rsp_err(rsp_err), .rsp_way(rsp_way), .rsp_victim(rsp_victim));

   int total = 0, bad = 0;
   bit finished = 1'b0;

   // behavioural model of every way
   int m_vld [SETS][ASSOC], m_tag [SETS][ASSOC], m_perm [SETS][ASSOC];
   int m_lk [SETS][ASSOC], m_own [SETS][ASSOC], m_pl [SETS][ASSOC];

   function automatic int mk(int t, int s, int lo = 0);
      return (t << (IDX_LO + SET_W)) | (s << IDX_LO) | lo;
   endfunction

   task automatic model_reset();
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < ASSOC; w++) begin
            m_vld[s][w] = 0; m_tag[s][w] = 0; m_perm[s][w] = 0;
            m_lk[s][w] = 0; m_own[s][w] = 0; m_pl[s][w] = 0;
         end
   endtask

   task automatic model_touch(int s, int w);
      int node = 1;
      for (int l = 0; l < WAY_W; l++) begin
         int b = (w >> (WAY_W - 1 - l)) & 1;
         m_pl[s][node] = (b == 0) ? 1 : 0;
         node = node * 2 + b;
      end
   endtask

   function automatic int model_victim(int s);
      int node = 1, v = 0;
      for (int l = 0; l < WAY_W; l++) begin
         int b = m_pl[s][node];
         v = v * 2 + b;
         node = node * 2 + b;
      end
      return v;
   endfunction

   task automatic check(string rq, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   task automatic cmd(int op, int line, int kind, int ctx, int pm, string rq);
      int s = (line >> IDX_LO) % SETS;
      int h = -1, f = -1, tm = 0;
      int e_ok = 0, e_err = 0, e_way = 0, e_vic = 0;
      for (int w = ASSOC - 1; w >= 0; w--) begin
         if (m_vld[s][w] != 0 && m_tag[s][w] == line) begin
            tm = 1;
            if (m_perm[s][w] != 0) h = w;
         end
         if (m_vld[s][w] == 0 || m_perm[s][w] == 0) f = w;
      end
      case (op)
         0: if (h >= 0) begin
               e_way = h;
               e_ok = (m_perm[s][h] == 3) || (m_perm[s][h] == 2 && kind <= 1);
               model_touch(s, h);
            end
         1: begin e_ok = (h >= 0); e_way = (h >= 0) ? h : 0; end
         2: e_ok = tm || (f >= 0);
         3: if (h >= 0 || f < 0) e_err = 1;
            else begin
               e_ok = 1; e_way = f;
               m_vld[s][f] = 1; m_tag[s][f] = line; m_perm[s][f] = 1;
               m_lk[s][f] = 0; m_own[s][f] = 0;
               model_touch(s, f);
            end
         5: if (tm || f >= 0) e_err = 1;
            else begin
               e_ok = 1; e_way = model_victim(s); e_vic = m_tag[s][e_way];
            end
         6: if (h >= 0) begin e_ok = 1; e_way = h; model_touch(s, h); end
         default: if (h < 0) e_err = 1;
            else begin
               e_way = h; e_ok = 1;
               if (op == 4) m_vld[s][h] = 0;
               if (op == 10) m_perm[s][h] = pm;
               if (op == 7) begin m_lk[s][h] = 1; m_own[s][h] = ctx; end
               if (op == 8) m_lk[s][h] = 0;
               if (op == 9) e_ok = (m_lk[s][h] != 0 && m_own[s][h] == ctx);
            end
      endcase
      @(negedge clk);
      req_op = 4'(op); req_line = LINE_W'(line); req_kind = 2'(kind);
      req_ctx = CTX_W'(ctx); req_perm = 2'(pm); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      total++;
      if (rsp_valid !== 1'b1 || int'(rsp_ok) != e_ok || int'(rsp_err) != e_err ||
          int'(rsp_way) != e_way || int'(rsp_victim) != e_vic) begin
         bad++;
         $display("FAIL %s op=%0d line=%0h: actual v=%0d ok=%0d err=%0d way=%0d vic=%0h expected v=1 ok=%0d err=%0d way=%0d vic=%0h",
                  rq, op, line, rsp_valid, rsp_ok, rsp_err, rsp_way, rsp_victim,
                  e_ok, e_err, e_way, e_vic);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
   end

   initial begin
      int a, b, c, d, e, g;
      a = mk(1, 0); b = mk(2, 0); c = mk(3, 0); d = mk(4, 0); e = mk(5, 0); g = mk(6, 0);
      do_reset();
      @(negedge clk);
      check("R1", "rsp_valid after reset", int'(rsp_valid), 0);
      check("R1", "req_ready after reset", int'(req_ready), 1);
      cmd(1, a, 0, 0, 0, "R1");
      cmd(2, a, 0, 0, 0, "R5");
      // fill set 0
      cmd(3, a, 0, 0, 0, "R6");
      cmd(3, b, 0, 0, 0, "R6");
      cmd(3, c, 0, 0, 0, "R6");
      cmd(3, d, 0, 0, 0, "R6");
      cmd(0, a, 0, 0, 0, "R3");        // invalid permission denies
      cmd(1, a, 0, 0, 0, "R2");
      cmd(10, a, 0, 0, 2, "R9");
      cmd(0, a, 0, 0, 0, "R3");
      cmd(0, a, 1, 0, 0, "R3");
      cmd(0, a, 2, 0, 0, "R3");
      cmd(0, a, 3, 0, 0, "R3");
      cmd(10, b, 0, 0, 3, "R9");
      cmd(0, b, 2, 0, 0, "R3");
      cmd(0, b, 3, 0, 0, "R3");
      cmd(2, e, 0, 0, 0, "R5");
      cmd(2, a, 0, 0, 0, "R5");
      cmd(3, e, 0, 0, 0, "R10");
      cmd(3, a, 0, 0, 0, "R10");
      cmd(5, e, 0, 0, 0, "R7");
      cmd(6, c, 0, 0, 0, "R4");
      cmd(5, e, 0, 0, 0, "R7");
      cmd(0, d, 2, 0, 0, "R4");        // denied but still promoted
      cmd(5, e, 0, 0, 0, "R7");
      cmd(6, e, 0, 0, 0, "R4");        // miss leaves tree alone
      cmd(5, e, 0, 0, 0, "R4");
      cmd(5, mk(1, 1), 0, 0, 0, "R10");
      // locks
      cmd(7, a, 0, 5, 0, "R8");
      cmd(9, a, 0, 5, 0, "R8");
      cmd(9, a, 0, 3, 0, "R8");
      cmd(8, a, 0, 5, 0, "R8");
      cmd(9, a, 0, 5, 0, "R8");
      cmd(7, e, 0, 5, 0, "R10");
      cmd(9, e, 0, 5, 0, "R10");
      cmd(7, c, 0, 9, 0, "R8");
      // deallocate and refill
      cmd(4, c, 0, 0, 0, "R9");
      cmd(1, c, 0, 0, 0, "R9");
      cmd(4, c, 0, 0, 0, "R10");
      cmd(10, c, 0, 0, 3, "R10");
      cmd(2, e, 0, 0, 0, "R5");
      cmd(5, e, 0, 0, 0, "R10");
      cmd(3, e, 0, 0, 0, "R6");
      cmd(9, e, 0, 9, 0, "R6");        // fresh line has no lock owner
      cmd(10, b, 0, 0, 0, "R9");
      cmd(1, b, 0, 0, 0, "R2");
      cmd(2, b, 0, 0, 0, "R5");
      cmd(3, g, 0, 0, 0, "R6");
      cmd(5, mk(7, 0), 0, 0, 0, "R7");
      // index position and tag width
      cmd(1, mk(1, 0, 1), 0, 0, 0, "R12");
      cmd(3, mk(1, 0, 1), 0, 0, 0, "R10");
      cmd(3, mk(1, 1), 0, 0, 0, "R12");
      cmd(3, mk(1, 1, 3), 0, 0, 0, "R12");
      cmd(1, mk(1, 1), 0, 0, 0, "R12");
      cmd(1, mk(1, 2), 0, 0, 0, "R12");
      // response back-pressure
      @(negedge clk);
      rsp_ready = 1'b0;
      cmd(1, a, 0, 0, 0, "R11");
      check("R11", "req_ready while held", int'(req_ready), 0);
      @(negedge clk);
      check("R11", "rsp_valid held", int'(rsp_valid), 1);
      check("R11", "rsp_ok held", int'(rsp_ok), 1);
      rsp_ready = 1'b1;
      @(negedge clk);
      check("R11", "rsp_valid released", int'(rsp_valid), 0);
      // reset clears everything
      do_reset();
      @(negedge clk);
      check("R1", "rsp_valid after second reset", int'(rsp_valid), 0);
      cmd(1, a, 0, 0, 0, "R1");
      cmd(1, mk(1, 1), 0, 0, 0, "R1");
      cmd(3, a, 0, 0, 0, "R1");
      finish_run();
   end
endmodule